// File: doc/BRIEF.md
# Passive Matrix LCD Timing Generator

This block drives a monochrome or gray-scale passive-matrix LCD panel. It takes pixels from an upstream valid/ready stream, eight pixels per transfer, and slices every display line into words on a 16-bit panel data bus. The bus can be 1, 2, 4 or 8 lanes wide. The block also generates the four panel strobes. The shift clock makes the panel driver take one word. A line strobe after the last word of a line latches the whole row. A frame marker spans the first row of each frame. A drive-polarity level flips after a programmed number of frame markers, so the liquid crystal is refreshed with alternating bias.

Line length, lines per frame, bus width, the idle gap between lines and the polarity period come from static configuration inputs. The block captures them at each frame start. Each of the four strobes has its own output inversion bit, which takes effect at once. When the upstream source runs dry, the shift clock waits at its inactive level and no stale pixels are put on the bus.

Top module: `pmLcdTimer`

## Requirements
- R1: While reset is held and just after it, every strobe output sits at its inactive level (sclk, line, frame and drive outputs equal polInv bits 0, 1, 2 and 3 respectively), lcdData is zero, and inReady is high.
- R2: Pixel p of the input stream is bit (p mod 8) of transfer p/8, and transfers are taken in order. In each shift word k of a line, lane j carries line pixel w*k+j, where w is the bus width. No pixel is skipped or repeated.
- R3: busSel values 0, 1, 2 and 3 select a bus width w of 1, 2, 4 and 8 lanes. A line of L pixels (L a multiple of 8) takes exactly L/w shift-clock active edges, and lcdData bits at w and above are always zero.
- R4: After the last word of each line, the line strobe is active for exactly LP_CYC clocks. The shift clock is never active while the line strobe is active.
- R5: When data is ready, the first shift-clock active level of a line other than the first comes idleClks+2 clocks after the line strobe of the previous line goes inactive.
- R6: The frame marker is active over every shift word of line 0 of a frame and over that line's strobe. It is inactive over all other lines, and it goes inactive in the same clock as line 0's strobe.
- R7: After lineCount lines (0 is taken as 1) the line counter wraps and the frame marker is asserted again.
- R8: The drive-polarity output changes only in the clock where the frame marker rises. It toggles on the N-th frame marker since its last toggle, where N is acdPeriod (0 is taken as 1).
- R9: polInv bit 0 inverts the shift clock, bit 1 the line strobe, bit 2 the frame marker and bit 3 the drive-polarity output. Each takes effect without changing the timing.
- R10: When no pixel group is held, the shift clock stays inactive and lcdData reads zero until a transfer arrives. Every non-zero word on lcdData is followed by, or coincides with, an active shift-clock level.
- R11: busSel, lineLen, lineCount, idleClks and acdPeriod are captured only at a frame start. A change made during a frame leaves the rest of that frame unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Upstream pixel group valid |
| inReady | output | 1 | Block can take a pixel group |
| inData | input | 8 | Eight pixels, lowest bit first in line order |
| busSel | input | 2 | Bus width select (1/2/4/8 lanes) |
| lineLen | input | LEN_W | Pixels per line, multiple of 8 |
| lineCount | input | LINES_W | Lines per frame |
| idleClks | input | IDLE_W | Extra idle clocks between lines |
| acdPeriod | input | ACD_W | Frame markers per drive-polarity toggle |
| polInv | input | 4 | Per-strobe inversion: sclk, line, frame, drive |
| lcdData | output | LD_W | Panel data bus, low-justified |
| lcdSclk | output | 1 | Panel shift clock |
| lcdLp | output | 1 | Line strobe |
| lcdFlm | output | 1 | First-line frame marker |
| lcdAcd | output | 1 | Alternating drive-polarity level |

## Verification
The hardest state to reach from the ports is a configuration change that arrives inside a frame. It has to be seen to apply only at the next frame marker, while the pixel stream stays continuous across the change of bus width. The bench watches the line strobe and writes new width, length and line count just after line 0 of a frame ends. It then confirms that the next line still has the old word count and that later frames use the new one. Upstream starvation is reached with a source that offers a group only every fifth clock. This holds the shift clock mid-line and checks that no pixel is lost or repeated.

// File: rtl/lcdPkg.sv
package lcdPkg;

  localparam int GRP_W = 8;

  typedef enum logic [1:0] {
    ST_LOAD,
    ST_SHIFT,
    ST_LP,
    ST_IDLE
  } lcdStateT;

  typedef struct packed {
    logic       drive;
    logic       sclk;
    logic       lp;
    logic       flm;
    logic       acd;
    logic       advance;
    logic [1:0] busSel;
  } lcdStrobeT;

  function automatic int busWidth(input logic [1:0] sel);
    return 1 << sel;
  endfunction

endpackage

// File: rtl/lcdControl.sv
module lcdControl
  import lcdPkg::*;
#(
  parameter int LEN_W   = 10,
  parameter int LINES_W = 10,
  parameter int IDLE_W  = 4,
  parameter int ACD_W   = 8,
  parameter int LP_CYC  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               grpFull,
  input  logic [1:0]         busSel,
  input  logic [LEN_W-1:0]   lineLen,
  input  logic [LINES_W-1:0] lineCount,
  input  logic [IDLE_W-1:0]  idleClks,
  input  logic [ACD_W-1:0]   acdPeriod,
  output lcdStrobeT          st
);

  localparam int LP_CW = (LP_CYC > 1) ? $clog2(LP_CYC) : 1;

  lcdStateT           state;
  logic               phase;
  logic [LEN_W-1:0]   pixCnt;
  logic [LINES_W-1:0] lineIdx;
  logic [LP_CW-1:0]   lpCnt;
  logic [IDLE_W-1:0]  idleCnt;
  logic [ACD_W-1:0]   frameCnt;
  logic               acdLvl;
  logic [1:0]         cfgBus;
  logic [LEN_W-1:0]   cfgLen;
  logic [LINES_W-1:0] cfgLines;
  logic [IDLE_W-1:0]  cfgIdle;

  logic [LEN_W:0]     pixNext;
  logic               lineDone;
  logic               lastLine;
  logic               acdHit;

  always_comb begin
    pixNext  = {1'b0, pixCnt} + (LEN_W + 1)'(busWidth(cfgBus));
    lineDone = pixNext >= {1'b0, cfgLen};
    lastLine = ({1'b0, lineIdx} + 1'b1) >= {1'b0, cfgLines};
    acdHit   = ({1'b0, frameCnt} + 1'b1) >= {1'b0, acdPeriod};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_LOAD;
      phase    <= 1'b0;
      pixCnt   <= '0;
      lineIdx  <= '0;
      lpCnt    <= '0;
      idleCnt  <= '0;
      frameCnt <= '0;
      acdLvl   <= 1'b0;
      cfgBus   <= '0;
      cfgLen   <= '0;
      cfgLines <= '0;
      cfgIdle  <= '0;
    end else begin
      case (state)
        ST_LOAD: begin
          cfgBus   <= busSel;
          cfgLen   <= lineLen;
          cfgLines <= lineCount;
          cfgIdle  <= idleClks;
          lineIdx  <= '0;
          pixCnt   <= '0;
          phase    <= 1'b0;
          if (acdHit) begin
            acdLvl   <= ~acdLvl;
            frameCnt <= '0;
          end else begin
            frameCnt <= frameCnt + 1'b1;
          end
          state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (!phase) begin
            if (grpFull) phase <= 1'b1;
          end else begin
            phase  <= 1'b0;
            pixCnt <= pixNext[LEN_W-1:0];
            if (lineDone) begin
              state <= ST_LP;
              lpCnt <= '0;
            end
          end
        end
        ST_LP: begin
          if (lpCnt == LP_CW'(LP_CYC - 1)) begin
            state   <= ST_IDLE;
            idleCnt <= '0;
          end else begin
            lpCnt <= lpCnt + 1'b1;
          end
        end
        default: begin
          if (idleCnt >= cfgIdle) begin
            if (lastLine) begin
              state <= ST_LOAD;
            end else begin
              lineIdx <= lineIdx + 1'b1;
              pixCnt  <= '0;
              state   <= ST_SHIFT;
            end
          end else begin
            idleCnt <= idleCnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    st.drive   = (state == ST_SHIFT) && grpFull;
    st.sclk    = (state == ST_SHIFT) && phase;
    st.advance = (state == ST_SHIFT) && phase;
    st.lp      = (state == ST_LP);
    st.flm     = ((state == ST_SHIFT) || (state == ST_LP)) && (lineIdx == '0);
    st.acd     = acdLvl;
    st.busSel  = cfgBus;
  end

  // R10
  sclk_has_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.sclk |-> grpFull);

  // R3
  pix_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_SHIFT) && (cfgLen != '0)) |-> (pixCnt < cfgLen));

endmodule

// File: rtl/lcdDatapath.sv
module lcdDatapath
  import lcdPkg::*;
#(
  parameter int LD_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [GRP_W-1:0] inData,
  output logic             inReady,
  input  lcdStrobeT        st,
  output logic             grpFull,
  output logic [LD_W-1:0]  ldRaw,
  output logic             sclkRaw,
  output logic             lpRaw,
  output logic             flmRaw,
  output logic             acdRaw
);

  localparam int OFF_W = $clog2(GRP_W);
  localparam int SUM_W = OFF_W + 1;

  logic [GRP_W-1:0] grpReg;
  logic [GRP_W-1:0] shifted;
  logic [OFF_W-1:0] bitOff;
  logic [SUM_W-1:0] offSum;
  logic             consume;
  logic [LD_W-1:0]  ldNext;

  always_comb begin
    offSum  = {1'b0, bitOff} + SUM_W'(busWidth(st.busSel));
    consume = st.advance && (offSum >= SUM_W'(GRP_W));
    inReady = !grpFull || consume;
    shifted = grpReg >> bitOff;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grpReg  <= '0;
      grpFull <= 1'b0;
      bitOff  <= '0;
    end else begin
      if (st.advance) bitOff <= offSum[OFF_W-1:0];
      if (inValid && inReady) begin
        grpReg  <= inData;
        grpFull <= 1'b1;
      end else if (consume) begin
        grpFull <= 1'b0;
      end
    end
  end

  generate
    for (genvar j = 0; j < LD_W; j++) begin : gLane
      if (j < GRP_W) begin : gLive
        assign ldNext[j] = st.drive && (j < busWidth(st.busSel)) && shifted[j];
      end else begin : gTie
        assign ldNext[j] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldRaw   <= '0;
      sclkRaw <= 1'b0;
      lpRaw   <= 1'b0;
      flmRaw  <= 1'b0;
      acdRaw  <= 1'b0;
    end else begin
      ldRaw   <= ldNext;
      sclkRaw <= st.sclk;
      lpRaw   <= st.lp;
      flmRaw  <= st.flm;
      acdRaw  <= st.acd;
    end
  end

  // R10
  grp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grpFull && !consume) |=> $stable(grpReg));

  // R4
  lp_no_sclk_chk: assert property (@(posedge clk) disable iff (!rstN)
    lpRaw |-> !sclkRaw);

  // R6
  flm_ends_with_lp_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flmRaw) |-> $fell(lpRaw));

  // R8
  acd_at_flm_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(acdRaw) |-> $rose(flmRaw));

endmodule

// File: rtl/pmLcdTimer.sv
module pmLcdTimer
  import lcdPkg::*;
#(
  parameter int LD_W    = 16,
  parameter int LEN_W   = 10,
  parameter int LINES_W = 10,
  parameter int IDLE_W  = 4,
  parameter int ACD_W   = 8,
  parameter int LP_CYC  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [7:0]         inData,
  input  logic [1:0]         busSel,
  input  logic [LEN_W-1:0]   lineLen,
  input  logic [LINES_W-1:0] lineCount,
  input  logic [IDLE_W-1:0]  idleClks,
  input  logic [ACD_W-1:0]   acdPeriod,
  input  logic [3:0]         polInv,
  output logic [LD_W-1:0]    lcdData,
  output logic               lcdSclk,
  output logic               lcdLp,
  output logic               lcdFlm,
  output logic               lcdAcd
);

  lcdStrobeT st;
  logic      grpFull;
  logic      sclkRaw;
  logic      lpRaw;
  logic      flmRaw;
  logic      acdRaw;

  lcdControl #(
    .LEN_W  (LEN_W),
    .LINES_W(LINES_W),
    .IDLE_W (IDLE_W),
    .ACD_W  (ACD_W),
    .LP_CYC (LP_CYC)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .grpFull  (grpFull),
    .busSel   (busSel),
    .lineLen  (lineLen),
    .lineCount(lineCount),
    .idleClks (idleClks),
    .acdPeriod(acdPeriod),
    .st       (st)
  );

  lcdDatapath #(
    .LD_W(LD_W)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .inData (inData),
    .inReady(inReady),
    .st     (st),
    .grpFull(grpFull),
    .ldRaw  (lcdData),
    .sclkRaw(sclkRaw),
    .lpRaw  (lpRaw),
    .flmRaw (flmRaw),
    .acdRaw (acdRaw)
  );

  assign lcdSclk = sclkRaw ^ polInv[0];
  assign lcdLp   = lpRaw   ^ polInv[1];
  assign lcdFlm  = flmRaw  ^ polInv[2];
  assign lcdAcd  = acdRaw  ^ polInv[3];

endmodule

// File: tb/sim_pmLcdTimer.sv
module sim_pmLcdTimer;

  localparam int CLK_PERIOD = 10;
  localparam int LP_CYC     = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [7:0]  inData = '0;
  logic [1:0]  busSel = 2'd2;
  logic [9:0]  lineLen = 10'd32;
  logic [9:0]  lineCount = 10'd3;
  logic [3:0]  idleClks = 4'd2;
  logic [7:0]  acdPeriod = 8'd2;
  logic [3:0]  polInv = 4'd0;
  logic [15:0] lcdData;
  logic        lcdSclk, lcdLp, lcdFlm, lcdAcd;

  int checks = 0, failures = 0;
  bit done = 0;
  bit stallMode = 0;

  int grpIdx = 0, feedCyc = 0;
  bit pend = 0;

  bit prevSc, prevLp, prevFl, prevAc;
  logic [15:0] prevLd;
  int expPix = 0, lineWords = 0, lastLineWords = 0, lpRun = 0;
  int gapCnt = 0; bit gapArmed = 0; bit frameActive = 0;
  int effW = 1, effLen = 0, effLines = 1, effIdle = 0, effN = 1;
  int linesInFrame = 0, flmSince = 0;
  int wordsSeen = 0, linesSeen = 0, flmRises = 0, acdToggles = 0, gapChecks = 0;
  int laneErr = 0, upperErr = 0, lineWordErr = 0, overlapErr = 0, lpLenErr = 0;
  int gapErr = 0, flmErr = 0, frameErr = 0, acdErr = 0, stallErr = 0;

  pmLcdTimer u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .busSel(busSel), .lineLen(lineLen), .lineCount(lineCount), .idleClks(idleClks),
    .acdPeriod(acdPeriod), .polInv(polInv), .lcdData(lcdData), .lcdSclk(lcdSclk),
    .lcdLp(lcdLp), .lcdFlm(lcdFlm), .lcdAcd(lcdAcd)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] pattern(input int g);
    int v;
    v = g * 29 + 11;
    return 8'(v ^ (g >> 2));
  endfunction

  function automatic bit pixBit(input int p);
    logic [7:0] g;
    g = pattern(p / 8);
    return g[p % 8];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // upstream source
  always @(negedge clk) begin
    if (!rstN) begin
      grpIdx = 0; feedCyc = 0; pend = 0; inValid = 1'b0;
    end else begin
      if (pend) grpIdx++;
      feedCyc++;
      inValid = stallMode ? (feedCyc % 5 == 0) : 1'b1;
      inData  = pattern(grpIdx);
      pend    = inValid && inReady;
    end
  end

  // output monitor
  always @(negedge clk) begin
    bit sc, lp, fl, ac, flRise;
    sc = lcdSclk ^ polInv[0];
    lp = lcdLp   ^ polInv[1];
    fl = lcdFlm  ^ polInv[2];
    ac = lcdAcd  ^ polInv[3];
    if (!rstN) begin
      prevSc = 0; prevLp = 0; prevFl = 0; prevAc = 0; prevLd = '0;
      expPix = 0; lineWords = 0; lpRun = 0; gapArmed = 0; gapCnt = 0;
      frameActive = 0; linesInFrame = 0; flmSince = 0;
    end else begin
      flRise = fl && !prevFl;
      if (gapArmed) gapCnt++;
      if (flRise) begin
        if (frameActive && linesInFrame != effLines) frameErr++;
        frameActive = 1;
        effW = 1 << busSel; effLen = lineLen; effIdle = idleClks;
        effLines = (lineCount == 0) ? 1 : lineCount;
        effN = (acdPeriod == 0) ? 1 : acdPeriod;
        linesInFrame = 0; flmRises++; flmSince++;
      end
      if (ac != prevAc) begin
        if (!flRise || flmSince < effN) acdErr++;
        flmSince = 0; acdToggles++;
      end else if (flRise && flmSince >= effN) begin
        acdErr++;
      end
      if (sc && !prevSc) begin
        if ((lcdData >> effW) != 0) upperErr++;
        for (int j = 0; j < effW; j++)
          if (lcdData[j] != pixBit(expPix + j)) laneErr++;
        expPix += effW; lineWords++; wordsSeen++;
        if (fl != (linesInFrame == 0)) flmErr++;
        if (gapArmed) begin
          if (!fl && !stallMode) begin
            gapChecks++;
            if (gapCnt != effIdle + 2) gapErr++;
          end
          gapArmed = 0;
        end
      end
      if (sc && lp) overlapErr++;
      if (prevLd != 0 && !prevSc && !sc) stallErr++;
      if (lp) lpRun++;
      if (lp && !prevLp) begin
        linesSeen++;
        if (lineWords * effW != effLen) lineWordErr++;
        lastLineWords = lineWords; lineWords = 0;
        if (fl != (linesInFrame == 0)) flmErr++;
        linesInFrame++;
      end
      if (!lp && prevLp) begin
        if (lpRun != LP_CYC) lpLenErr++;
        lpRun = 0; gapArmed = 1; gapCnt = 0;
      end
      prevSc = sc; prevLp = lp; prevFl = fl; prevAc = ac; prevLd = lcdData;
    end
  end

  task automatic waitFrames(input int n);
    int target, t;
    target = flmRises + n; t = 0;
    while (flmRises < target && t < 50000) begin @(negedge clk); t++; end
    check(flmRises >= target, "timeout waiting for frames", flmRises, target);
  endtask

  task automatic waitLines(input int n);
    int target, t;
    target = linesSeen + n; t = 0;
    while (linesSeen < target && t < 50000) begin @(negedge clk); t++; end
    check(linesSeen >= target, "timeout waiting for lines", linesSeen, target);
  endtask

  task automatic testReset();
    polInv = 4'd0; rstN = 1'b0;
    repeat (4) @(negedge clk);
    // R1
    check({lcdAcd, lcdFlm, lcdLp, lcdSclk} == 4'd0, "R1 strobes in reset", {lcdAcd, lcdFlm, lcdLp, lcdSclk}, 0);
    check(lcdData == 0, "R1 data in reset", lcdData, 0);
    check(inReady == 1'b1, "R1 ready in reset", inReady, 1);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(lcdData == 0 && lcdSclk == 0, "R1 idle after reset", lcdData, 0);
  endtask

  task automatic testMainFrame();
    int w0, g0;
    w0 = wordsSeen; g0 = gapChecks;
    waitFrames(5);
    // R2
    check(laneErr == 0 && wordsSeen > w0, "R2 lane order 4-bit", laneErr, 0);
    // R3
    check(upperErr == 0, "R3 upper bits zero", upperErr, 0);
    check(lineWordErr == 0 && linesSeen > 0, "R3 words per line", lineWordErr, 0);
    // R4
    check(overlapErr == 0 && lpLenErr == 0, "R4 line strobe", overlapErr + lpLenErr, 0);
    // R5
    check(gapErr == 0 && gapChecks > g0, "R5 idle gap", gapErr, 0);
    // R6
    check(flmErr == 0, "R6 frame marker span", flmErr, 0);
    // R7
    check(frameErr == 0 && flmRises >= 5, "R7 frame wrap", frameErr, 0);
  endtask

  task automatic testWidths();
    int w0;
    for (int s = 0; s < 4; s++) begin
      waitLines(1);
      busSel = 2'(s); idleClks = 4'(s + 1);
      waitFrames(3);
      w0 = wordsSeen;
      waitFrames(1);
      // R3
      check(lineWordErr == 0 && upperErr == 0, "R3 width variant", lineWordErr + upperErr, 0);
      // R2
      check(laneErr == 0 && wordsSeen - w0 == 3 * 32 / (1 << s), "R2 lanes per width", wordsSeen - w0, 3 * 32 / (1 << s));
      // R5
      check(gapErr == 0, "R5 gap per idle", gapErr, 0);
    end
  endtask

  task automatic testAcd();
    int a0;
    for (int n = 0; n < 4; n++) begin
      waitLines(1);
      acdPeriod = 8'(n);
      waitFrames(2);
      a0 = acdToggles;
      waitFrames(6);
      // R8
      check(acdErr == 0, "R8 toggle placement", acdErr, 0);
      check(acdToggles - a0 >= 6 / ((n == 0) ? 1 : n) - 1, "R8 toggle rate", acdToggles - a0, 6 / ((n == 0) ? 1 : n) - 1);
    end
  endtask

  task automatic testStall();
    int w0;
    waitLines(1);
    stallMode = 1;
    w0 = wordsSeen;
    waitFrames(3);
    // R10
    check(stallErr == 0, "R10 no stale data", stallErr, 0);
    check(laneErr == 0 && wordsSeen > w0, "R10 no lost pixels", laneErr, 0);
    check(lineWordErr == 0, "R10 line length under stall", lineWordErr, 0);
    stallMode = 0;
    waitFrames(1);
  endtask

  task automatic testCfgLatch();
    busSel = 2'd2; lineLen = 10'd32; lineCount = 10'd3;
    waitFrames(2);
    waitLines(1);
    busSel = 2'd3; lineLen = 10'd16; lineCount = 10'd2;
    waitLines(1);
    // R11
    check(lastLineWords == 8, "R11 old width kept mid-frame", lastLineWords, 8);
    waitFrames(2);
    waitLines(1);
    check(lastLineWords == 2, "R11 new config next frame", lastLineWords, 2);
    check(lineWordErr == 0 && frameErr == 0 && laneErr == 0, "R11 latch integrity", lineWordErr + frameErr + laneErr, 0);
  endtask

  task automatic testPolarity();
    int w0;
    rstN = 1'b0; polInv = 4'b1010;
    repeat (3) @(negedge clk);
    // R9
    check({lcdAcd, lcdFlm, lcdLp, lcdSclk} == 4'b1010, "R9 inverted idle levels", {lcdAcd, lcdFlm, lcdLp, lcdSclk}, 4'b1010);
    busSel = 2'd1; lineLen = 10'd24; lineCount = 10'd4; acdPeriod = 8'd1; idleClks = 4'd1;
    @(negedge clk); rstN = 1'b1;
    w0 = wordsSeen;
    waitFrames(3);
    polInv = 4'b0101;
    waitFrames(3);
    check(laneErr == 0 && flmErr == 0 && acdErr == 0 && overlapErr == 0 && wordsSeen > w0,
          "R9 timing under inversion", laneErr + flmErr + acdErr + overlapErr, 0);
    check(lpLenErr == 0 && gapErr == 0 && frameErr == 0, "R9 strobe shape under inversion", lpLenErr + gapErr + frameErr, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    testReset();
    testMainFrame();
    testWidths();
    testAcd();
    testStall();
    testCfgLatch();
    testPolarity();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule